// File: doc/BRIEF.md
# EEPROM Identity Record Checker

This block sits behind a serial-memory reader and inspects the identity record as the bytes stream past, one byte per accepted cycle. It keeps a running byte sum over the part of the record covered by the record's own length byte. It also latches the length byte, the stored checksum byte and the eight GUID octets from fixed offsets. When the final byte arrives it judges the record. The checksum must match, and the GUID must be neither all zeros nor all ones. A known factory-default GUID raises a warning but is still accepted. A GUID stored in the legacy layout, with its top three octets zero, is rewritten into the current layout.

A board can carry several units that share one stored base GUID. For such units the block does not take the GUID from the record. It builds the GUID from the base GUID and the unit number instead. The unit number is added to the lowest octet, and a carry ripples upward into octets 6 and 5. The block reports an error if that carry would reach octet 4.

The control is a three-state machine. `ST_IDLE` is the state after reset, before any record has been seen. `ST_RECV` means a record is being received. `ST_DONE` means the results are valid and held. The transitions are named as follows:
- **open**: an accepted start byte that is not also a last byte moves the machine from any state to `ST_RECV`.
- **close**: an accepted last byte moves the machine from any state to `ST_DONE`.
- **stay**: every other cycle keeps the current state.

Octet 0 of a GUID is its most significant byte, and it is the first GUID byte in the stream.

Top module: `ident_rec_check`

## Requirements
- R1: After reset `res_valid`, `csum_ok`, `guid_valid`, `dflt_warn` and `derive_err` are 0, and `guid_out` is 0.
- R2: `res_valid` goes to 1 in the cycle after an accepted byte with `in_last` = 1. All result outputs then stay unchanged until the next accepted start byte, and `res_valid` falls in the cycle after that start byte.
- R3: Byte index 0 is the start byte. The length byte sits at index LEN_POS (default 0) and the stored checksum at index CSUM_POS (default 1). A byte is summed if its index is at most LEN_POS or below the length value. The computed checksum is the bitwise inverse of the 8-bit sum minus the stored byte. `csum_ok` is 1 exactly when the computed checksum equals the stored byte. Missing bytes read as 0.
- R4: The GUID is taken from indices GUID_POS..GUID_POS+7 (default 2..9), with octet 0 first and most significant. Outside derive mode, `guid_valid` is 1 only if `csum_ok` is 1 and the raw GUID is neither 0 nor all ones. When `guid_valid` is 0, `guid_out` is 0.
- R5: `dflt_warn` is 1 only when a valid, non-derived GUID equals 64'h0100007511000000.
- R6: If a valid raw GUID has octets 0 to 2 equal to zero, `guid_out` has octet 1 set to raw octet 3 and octet 2 set to raw octet 4. Octets 3 and 4 become zero, and the rest are unchanged.
- R7: Derive mode holds when `unit_num` is not 0, `base_count` is above 1 and `unit_num` is at most `base_count`. In derive mode `guid_out` is `base_guid` with `unit_num` added modulo 256 to octet 7 (bits 7:0). `guid_valid` is the inverse of `derive_err`, and `dflt_warn` is 0. The mode inputs are sampled with the last byte.
- R8: If the octet 7 addition wraps, octet 6 (bits 15:8) is incremented. If octet 6 was 8'hFF, octet 5 (bits 23:16) is also incremented and octet 6 becomes 8'h00.
- R9: If the wrap reaches octet 6 = 8'hFF with octet 5 = 8'hFF, `derive_err` is 1, `guid_out` is 0 and `guid_valid` is 0.
- R10: An accepted start byte in the middle of a record discards the partial record, and the new record is judged alone.
- R11: Bytes with `in_valid` = 0 are ignored. Valid bytes that arrive with no open record (no start since the last close) are also ignored, and so are their `in_last` flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Byte strobe |
| in_start | input | 1 | Marks the first byte of a record |
| in_last | input | 1 | Marks the final byte of a record |
| in_byte | input | 8 | Record byte |
| unit_num | input | 8 | Unit index for GUID derivation |
| base_count | input | 8 | Number of GUIDs the base covers |
| base_guid | input | 64 | Base GUID for derived units |
| res_valid | output | 1 | Results valid and held |
| csum_ok | output | 1 | Stored checksum matches |
| guid_valid | output | 1 | `guid_out` is usable |
| dflt_warn | output | 1 | GUID is the factory default |
| derive_err | output | 1 | Derivation carried past octet 5 |
| guid_out | output | 64 | Final GUID |

## Verification
Two events can land in the same accepted byte. A start byte can also be a last byte, which closes a one-byte record. A start byte can also arrive while a record is still open, which discards it. The bench sends a partial record, restarts it with a full record, and requires that only the second record shape the results. During held results it also sends stray valid bytes that carry `in_last` but no start, and requires that no output moves. In all of these cases the outputs are compared with a bench model of the requirements.

// File: rtl/ident_rec_pkg.sv
package ident_rec_pkg;

    localparam int OCTET_W = 8;
    localparam int GUID_W  = 64;
    localparam int GUID_OCTETS = GUID_W / OCTET_W;

    localparam logic [GUID_W-1:0] GUID_FACTORY = 64'h0100007511000000;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RECV = 2'd1,
        ST_DONE = 2'd2
    } rec_state_e;

    typedef struct packed {
        logic              csum_ok;
        logic              guid_valid;
        logic              dflt_warn;
        logic              derive_err;
        logic [GUID_W-1:0] guid;
    } rec_result_t;

endpackage

// File: rtl/rec_byte_track.sv
module rec_byte_track
    import ident_rec_pkg::*;
#(
    parameter int IDX_W    = 8,
    parameter int LEN_POS  = 0,
    parameter int CSUM_POS = 1,
    parameter int GUID_POS = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               take,
    input  logic               first,
    input  logic [OCTET_W-1:0] dat,
    output logic [OCTET_W-1:0] sum_nx,
    output logic [OCTET_W-1:0] stored_nx,
    output logic [GUID_W-1:0]  guid_nx
);

    localparam logic [IDX_W-1:0] IDX_MAX = {IDX_W{1'b1}};
    localparam logic [IDX_W-1:0] LEN_I   = IDX_W'(LEN_POS);
    localparam logic [IDX_W-1:0] CSUM_I  = IDX_W'(CSUM_POS);

    logic [IDX_W-1:0]   idx_q,    base_idx, idx_nx;
    logic [OCTET_W-1:0] sum_q,    base_sum;
    logic [OCTET_W-1:0] len_q,    base_len, len_nx;
    logic [OCTET_W-1:0] stored_q, base_stored;
    logic [GUID_W-1:0]  guid_q,   base_guid;
    logic               counted;

    always_comb begin
        base_idx    = first ? '0 : idx_q;
        base_sum    = first ? '0 : sum_q;
        base_len    = first ? '0 : len_q;
        base_stored = first ? '0 : stored_q;
        base_guid   = first ? '0 : guid_q;
    end

    assign counted = (base_idx <= LEN_I) || (32'(base_idx) < 32'(base_len));

    always_comb begin
        idx_nx    = idx_q;
        sum_nx    = sum_q;
        len_nx    = len_q;
        stored_nx = stored_q;
        if (take) begin
            idx_nx    = (base_idx == IDX_MAX) ? base_idx : base_idx + 1'b1;
            sum_nx    = base_sum + (counted ? dat : '0);
            len_nx    = (base_idx == LEN_I)  ? dat : base_len;
            stored_nx = (base_idx == CSUM_I) ? dat : base_stored;
        end
    end

    for (genvar k = 0; k < GUID_OCTETS; k++) begin : g_octet
        localparam logic [IDX_W-1:0] SLOT = IDX_W'(GUID_POS + k);
        localparam int HI = GUID_W - 1 - k * OCTET_W;
        always_comb begin
            guid_nx[HI -: OCTET_W] = guid_q[HI -: OCTET_W];
            if (take) begin
                guid_nx[HI -: OCTET_W] = (base_idx == SLOT) ? dat
                                       : base_guid[HI -: OCTET_W];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx_q    <= '0;
            sum_q    <= '0;
            len_q    <= '0;
            stored_q <= '0;
            guid_q   <= '0;
        end else begin
            idx_q    <= idx_nx;
            sum_q    <= sum_nx;
            len_q    <= len_nx;
            stored_q <= stored_nx;
            guid_q   <= guid_nx;
        end
    end

endmodule

// File: rtl/guid_screen.sv
module guid_screen
    import ident_rec_pkg::*;
(
    input  logic [GUID_W-1:0] raw,
    input  logic              sum_good,
    output logic              usable,
    output logic              factory,
    output logic [GUID_W-1:0] fixed
);

    logic legacy;
    logic [GUID_W-1:0] relaid;

    assign legacy = (raw[63:40] == 24'h0);

    always_comb begin
        relaid = raw;
        if (legacy) begin
            relaid[55:48] = raw[39:32];
            relaid[47:40] = raw[31:24];
            relaid[39:32] = 8'h00;
            relaid[31:24] = 8'h00;
        end
    end

    assign usable  = sum_good && (raw != '0) && (raw != '1);
    assign factory = usable && (raw == GUID_FACTORY);
    assign fixed   = usable ? relaid : '0;

endmodule

// File: rtl/guid_unit_derive.sv
module guid_unit_derive
    import ident_rec_pkg::*;
(
    input  logic [GUID_W-1:0]  base,
    input  logic [OCTET_W-1:0] unit,
    output logic [GUID_W-1:0]  derived,
    output logic               overflow
);

    logic [OCTET_W:0]   lo_sum;
    logic [OCTET_W-1:0] mid, up;

    assign lo_sum = {1'b0, base[7:0]} + {1'b0, unit};
    assign mid    = base[15:8];
    assign up     = base[23:16];

    always_comb begin
        overflow = 1'b0;
        derived  = {base[63:8], lo_sum[7:0]};
        if (lo_sum[OCTET_W]) begin
            if (mid != 8'hFF) begin
                derived = {base[63:16], mid + 8'h01, lo_sum[7:0]};
            end else if (up != 8'hFF) begin
                derived = {base[63:24], up + 8'h01, 8'h00, lo_sum[7:0]};
            end else begin
                overflow = 1'b1;
                derived  = '0;
            end
        end
    end

endmodule

// File: rtl/ident_rec_check.sv
module ident_rec_check
    import ident_rec_pkg::*;
#(
    parameter int IDX_W    = 8,
    parameter int LEN_POS  = 0,
    parameter int CSUM_POS = 1,
    parameter int GUID_POS = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        in_valid,
    input  logic        in_start,
    input  logic        in_last,
    input  logic [7:0]  in_byte,
    input  logic [7:0]  unit_num,
    input  logic [7:0]  base_count,
    input  logic [63:0] base_guid,
    output logic        res_valid,
    output logic        csum_ok,
    output logic        guid_valid,
    output logic        dflt_warn,
    output logic        derive_err,
    output logic [63:0] guid_out
);

    rec_state_e  state_q, state_d;
    rec_result_t res_q, res_d;

    logic               accept, close;
    logic [OCTET_W-1:0] sum_nx, stored_nx, calc;
    logic [GUID_W-1:0]  raw_guid, scr_guid, drv_guid;
    logic               sum_good, scr_ok, scr_warn, drv_err, derive_sel;

    assign accept = in_valid && (in_start || state_q == ST_RECV);
    assign close  = accept && in_last;

    rec_byte_track #(
        .IDX_W(IDX_W), .LEN_POS(LEN_POS), .CSUM_POS(CSUM_POS), .GUID_POS(GUID_POS)
    ) u_track (
        .clk(clk), .rst_n(rst_n), .take(accept), .first(in_start),
        .dat(in_byte), .sum_nx(sum_nx), .stored_nx(stored_nx), .guid_nx(raw_guid)
    );

    assign calc     = ~(sum_nx - stored_nx);
    assign sum_good = (calc == stored_nx);

    guid_screen u_screen (
        .raw(raw_guid), .sum_good(sum_good),
        .usable(scr_ok), .factory(scr_warn), .fixed(scr_guid)
    );

    guid_unit_derive u_derive (
        .base(base_guid), .unit(unit_num), .derived(drv_guid), .overflow(drv_err)
    );

    assign derive_sel = (unit_num != 8'd0) && (base_count > 8'd1)
                      && (unit_num <= base_count);

    always_comb begin
        res_d.csum_ok = sum_good;
        if (derive_sel) begin
            res_d.guid_valid = !drv_err;
            res_d.dflt_warn  = 1'b0;
            res_d.derive_err = drv_err;
            res_d.guid       = drv_guid;
        end else begin
            res_d.guid_valid = scr_ok;
            res_d.dflt_warn  = scr_warn;
            res_d.derive_err = 1'b0;
            res_d.guid       = scr_guid;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE, ST_RECV, ST_DONE: begin
                if (close)                    state_d = ST_DONE;
                else if (accept && in_start)  state_d = ST_RECV;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)     res_q <= '0;
        else if (close) res_q <= res_d;
    end

    assign res_valid  = (state_q == ST_DONE);
    assign csum_ok    = res_q.csum_ok;
    assign guid_valid = res_q.guid_valid;
    assign dflt_warn  = res_q.dflt_warn;
    assign derive_err = res_q.derive_err;
    assign guid_out   = res_q.guid;

endmodule

// File: rtl/ident_rec_check_sva.sv
module ident_rec_check_sva
    import ident_rec_pkg::*;
(
    input logic        clk,
    input logic        rst_n,
    input logic        in_valid,
    input logic        in_start,
    input logic        in_last,
    input logic        res_valid,
    input logic        csum_ok,
    input logic        guid_valid,
    input logic        dflt_warn,
    input logic        derive_err,
    input logic [63:0] guid_out
);

    p_rise_after_last_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(res_valid) |-> $past(in_valid && in_last));

    p_hold_stable_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && !(in_valid && in_start)) |=>
            (res_valid && $stable(guid_out) && $stable(csum_ok) && $stable(guid_valid)
             && $stable(dflt_warn) && $stable(derive_err)));

    p_invalid_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !guid_valid |-> (guid_out == 64'h0));

    p_warn_default_r5: assert property (@(posedge clk) disable iff (!rst_n)
        dflt_warn |-> (guid_valid && guid_out == GUID_FACTORY && !derive_err));

    p_err_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        derive_err |-> (!guid_valid && guid_out == 64'h0));

    p_drop_on_start_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_start && !in_last) |=> !res_valid);

endmodule

bind ident_rec_check ident_rec_check_sva u_sva (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_start(in_start),
    .in_last(in_last), .res_valid(res_valid), .csum_ok(csum_ok),
    .guid_valid(guid_valid), .dflt_warn(dflt_warn), .derive_err(derive_err),
    .guid_out(guid_out)
);

// File: tb/tb_ident_rec_check.sv
module tb_ident_rec_check;

    localparam int LP = 0;
    localparam int CP = 1;
    localparam int GP = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0, in_start = 1'b0, in_last = 1'b0;
    logic [7:0]  in_byte = 8'h00, unit_num = 8'h00, base_count = 8'h00;
    logic [63:0] base_guid = 64'h0;
    logic        res_valid, csum_ok, guid_valid, dflt_warn, derive_err;
    logic [63:0] guid_out;

    int total = 0;
    int bad = 0;
    int cycles = 0;

    logic [7:0] rec [0:31];
    logic       e_ok, e_valid, e_warn, e_err;
    logic [63:0] e_guid;

    ident_rec_check dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_start(in_start),
        .in_last(in_last), .in_byte(in_byte), .unit_num(unit_num),
        .base_count(base_count), .base_guid(base_guid), .res_valid(res_valid),
        .csum_ok(csum_ok), .guid_valid(guid_valid), .dflt_warn(dflt_warn),
        .derive_err(derive_err), .guid_out(guid_out)
    );

    always #4 clk = ~clk;

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 150000) begin
            bad = bad + 1;
            total = total + 1;
            $display("FAIL watchdog: actual=%0d cycles expected=done", cycles);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic check(input string tag, input logic [63:0] got, input logic [63:0] exp);
        total = total + 1;
        if (got !== exp) begin
            bad = bad + 1;
            $display("FAIL %s: actual=%h expected=%h", tag, got, exp);
        end
    endtask

    // Fill a record of n bytes with the given length byte and GUID; optionally fix checksum.
    task automatic make_rec(input int n, input logic [7:0] len, input logic [63:0] g, input bit fix);
        logic [7:0] s;
        for (int i = 0; i < 32; i++) rec[i] = 8'($urandom);
        rec[LP] = len;
        for (int k = 0; k < 8; k++) rec[GP + k] = g[63 - 8*k -: 8];
        if (fix) begin
            s = 8'h00;
            for (int i = 0; i < n; i++)
                if (i != CP && (i <= LP || i < int'(len))) s = s + rec[i];
            rec[CP] = ~s;
        end
    endtask

    task automatic compute_exp(input int n);
        logic [7:0] s, ln, st, lo;
        logic [63:0] raw, fx;
        logic [8:0] add;
        ln = (n > LP) ? rec[LP] : 8'h00;
        st = (n > CP) ? rec[CP] : 8'h00;
        s = 8'h00;
        for (int i = 0; i < n; i++) if (i <= LP || i < int'(ln)) s = s + rec[i];
        e_ok = ((~(s - st)) == st);
        raw = 64'h0;
        for (int k = 0; k < 8; k++) raw[63 - 8*k -: 8] = (GP + k < n) ? rec[GP + k] : 8'h00;
        if (unit_num != 0 && base_count > 1 && unit_num <= base_count) begin
            add = {1'b0, base_guid[7:0]} + {1'b0, unit_num};
            lo = add[7:0];
            e_warn = 1'b0;
            e_err = 1'b0;
            fx = base_guid;
            fx[7:0] = lo;
            if (add[8]) begin
                fx[15:8] = base_guid[15:8] + 8'h01;
                if (base_guid[15:8] == 8'hFF) begin
                    if (base_guid[23:16] == 8'hFF) e_err = 1'b1;
                    else fx[23:16] = base_guid[23:16] + 8'h01;
                end
            end
            e_valid = !e_err;
            e_guid = e_err ? 64'h0 : fx;
        end else begin
            e_err = 1'b0;
            e_valid = e_ok && raw != 64'h0 && raw != {64{1'b1}};
            e_warn = e_valid && raw == 64'h0100007511000000;
            fx = raw;
            if (raw[63:40] == 24'h0) fx = {8'h00, raw[39:32], raw[31:24], 16'h0000, raw[23:0]};
            e_guid = e_valid ? fx : 64'h0;
        end
    endtask

    task automatic send_rec(input int n, input bit gaps);
        for (int i = 0; i < n; i++) begin
            if (gaps && ($urandom % 3 == 0)) begin
                in_valid = 1'b0; in_start = 1'($urandom); in_last = 1'($urandom);
                in_byte = 8'($urandom);
                @(negedge clk);
            end
            in_valid = 1'b1; in_start = (i == 0); in_last = (i == n - 1); in_byte = rec[i];
            @(negedge clk);
        end
        in_valid = 1'b0; in_start = 1'b0; in_last = 1'b0;
    endtask

    task automatic run_check(input int n, input bit gaps, input string tag);
        send_rec(n, gaps);
        compute_exp(n);
        check({tag, " R2 res_valid"}, 64'(res_valid), 64'd1);
        check({tag, " R3 csum_ok"}, 64'(csum_ok), 64'(e_ok));
        check({tag, " R4 guid_valid"}, 64'(guid_valid), 64'(e_valid));
        check({tag, " R5 dflt_warn"}, 64'(dflt_warn), 64'(e_warn));
        check({tag, " R9 derive_err"}, 64'(derive_err), 64'(e_err));
        check({tag, " R6 guid_out"}, guid_out, e_guid);
    endtask

    initial begin
        logic [63:0] held;
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1 res_valid", 64'(res_valid), 64'd0);
        check("R1 flags", {60'd0, csum_ok, guid_valid, dflt_warn, derive_err}, 64'd0);
        check("R1 guid_out", guid_out, 64'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // R11: stray bytes before any start are ignored
        in_valid = 1'b1; in_last = 1'b1; in_byte = 8'h5A;
        @(negedge clk);
        in_valid = 1'b0; in_last = 1'b0;
        @(negedge clk);
        check("R11 stray last ignored", 64'(res_valid), 64'd0);

        // R5: factory GUID accepted with warning
        make_rec(16, 8'd12, 64'h0100007511000000, 1'b1);
        run_check(16, 1'b0, "default");
        check("R5 warn set", 64'(dflt_warn), 64'd1);

        // R4: all zeros and all ones rejected
        make_rec(16, 8'd16, 64'h0, 1'b1);
        run_check(16, 1'b1, "zeros");
        check("R4 zero rejected", 64'(guid_valid), 64'd0);
        make_rec(12, 8'd12, {64{1'b1}}, 1'b1);
        run_check(12, 1'b0, "ones");

        // R6: legacy layout repair
        make_rec(14, 8'd14, 64'h000000123456789A, 1'b1);
        run_check(14, 1'b0, "legacy");
        check("R6 relaid", guid_out, 64'h001234000056789A);

        // R3: corrupted checksum
        make_rec(14, 8'd10, 64'h0011223344556677, 1'b1);
        rec[CP] = rec[CP] ^ 8'h01;
        run_check(14, 1'b0, "badsum");
        check("R3 bad sum", 64'(csum_ok), 64'd0);

        // R2: results held while idle; R11: stray bytes ignored in hold
        make_rec(12, 8'd12, 64'h0A0B0C0D0E0F1011, 1'b1);
        run_check(12, 1'b0, "hold");
        held = guid_out;
        in_valid = 1'b1; in_last = 1'b1; in_byte = 8'hFF;
        repeat (4) @(negedge clk);
        in_valid = 1'b0; in_last = 1'b0;
        repeat (3) @(negedge clk);
        check("R2 held guid", guid_out, held);
        check("R11 still valid", 64'(res_valid), 64'd1);

        // R10: restart mid-record
        make_rec(12, 8'd12, 64'hDEADBEEF00000001, 1'b0);
        in_valid = 1'b1; in_start = 1'b1; in_byte = rec[0];
        @(negedge clk);
        in_start = 1'b0;
        check("R2 res_valid falls", 64'(res_valid), 64'd0);
        for (int i = 1; i < 6; i++) begin in_byte = rec[i]; @(negedge clk); end
        in_valid = 1'b0;
        make_rec(13, 8'd11, 64'h1122334455667788, 1'b1);
        run_check(13, 1'b1, "R10 restart");
        check("R10 restarted guid", guid_out, 64'h1122334455667788);

        // R7/R8/R9: derivation
        base_count = 8'd4; unit_num = 8'd3; base_guid = 64'h0011750000AB1020;
        make_rec(12, 8'd12, 64'h0, 1'b0);
        run_check(12, 1'b0, "R7 derive");
        check("R7 plain add", guid_out, 64'h0011750000AB1023);
        base_guid = 64'h0011750000AB10FE; unit_num = 8'd4;
        run_check(12, 1'b0, "R8 carry6");
        check("R8 carry into 6", guid_out, 64'h0011750000AB1102);
        base_guid = 64'h0011750000ABFFFF; unit_num = 8'd2;
        run_check(12, 1'b0, "R8 carry5");
        check("R8 carry into 5", guid_out, 64'h0011750000AC0001);
        base_guid = 64'h0011750000FFFFFF; unit_num = 8'd1;
        run_check(12, 1'b0, "R9 overflow");
        check("R9 err", 64'(derive_err), 64'd1);
        unit_num = 8'd5;
        make_rec(12, 8'd12, 64'h0203040506070809, 1'b1);
        run_check(12, 1'b0, "R7 unit above count");
        base_count = 8'd1; unit_num = 8'd1;
        run_check(12, 1'b0, "R7 count one");

        // random records
        for (int t = 0; t < 200; t++) begin
            int n;
            logic [7:0] ln;
            logic [63:0] g;
            n = 3 + int'($urandom % 20);
            ln = ($urandom % 4 == 0) ? 8'($urandom) : 8'(2 + ($urandom % (n - 1)));
            g = {$urandom, $urandom};
            if ($urandom % 6 == 0) g[63:40] = 24'h0;
            unit_num = ($urandom % 3 == 0) ? 8'($urandom % 6) : 8'd0;
            base_count = 8'($urandom % 6);
            base_guid = {$urandom, $urandom};
            if ($urandom % 2 == 0) base_guid[15:0] = 16'hFFFF;
            make_rec(n, ln, g, ($urandom % 4 != 0) && ln >= 8'd2);
            run_check(n, 1'($urandom), "random R3 R7");
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule